// File: doc/BRIEF.md
# DSP Accumulator Datapath Unit

This unit holds the two wide accumulators of a 16-bit signal-processing core and performs every operation that writes or reads them. On a single-cycle `start` strobe it takes an operation code, an accumulator index, two 16-bit register operands and a fractional-mode bit. One clock later it presents the result on `valid`. The operations are:

- unsigned multiply, multiply-accumulate and multiply-subtract;
- arithmetic and logical right shifts, with the amount taken either from a register or from an immediate;
- an equality test between the two accumulators;
- a rounded, saturating readout of an accumulator's upper half into a 16-bit register;
- a load of an accumulator from a register pair.

All accumulator arithmetic wraps modulo 2^40. In fractional mode each product is doubled before it is used. The compare and the readout keep a two-deep flag history: the old primary flag moves into the secondary flag before the primary flag is written. An operation that is not defined, or a register shift above 16, raises `illegal` and changes no state. After every operation `accOut` shows the accumulator that was addressed.

Top module: `dspAccUnit`

## Requirements
- R1: Each cycle with `start` high produces exactly one cycle of `valid` on the next clock. A cycle without `start` produces `valid` low on the next clock.
- R2: Operation code 1 (multiply) writes the selected accumulator with opA*opB. Both operands are treated as unsigned. When `fracMode` is 1 the product is first shifted left by one.
- R3: Operation code 2 (multiply-accumulate) adds the product defined in R2 to the selected accumulator, modulo 2^40.
- R4: Operation code 3 (multiply-subtract) subtracts the product defined in R2 from the selected accumulator, modulo 2^40.
- R5: Operation code 0 (load) writes the selected accumulator with the 32-bit value {opA, opB}, sign-extended from bit 31 to 40 bits.
- R6: Arithmetic right shift uses code 4 with the amount in opB[4:0], or code 6 with the amount in opB[3:0]. An immediate amount of 0 means 16. The vacated bits are filled with copies of bit 39.
- R7: Logical right shift uses code 5 (register amount) or code 7 (immediate amount), with the same amount rules as R6. The vacated bits are filled with zeros.
- R8: For codes 4 and 5, an amount in opB[4:0] above 16 sets `illegal` for that result. The accumulator and both flags are left unchanged.
- R9: Code 8 compares all 40 bits of accumulator 0 with accumulator 1. It moves the old `flagF0` into `flagF1` and sets `flagF0` to 1 when the two are equal.
- R10: Code 9 (readout) proceeds in four steps. It sign-extends the selected accumulator and shifts it by the signed amount opB[2:0]: a non-negative amount shifts left, a negative amount shifts right arithmetically. It adds 0x8000. When the sum lies within the signed 32-bit range, `regOut` takes bits 31:16 of the sum and `flagF0` is cleared. Old `flagF0` moves into `flagF1`.
- R11: In a readout, a sum above 0x7FFFFFFF gives `regOut` 0x7FFF, and a sum below -0x80000000 gives 0x8000. In both cases `flagF0` is set. The limit values themselves do not saturate.
- R12: Codes 10 to 15 set `illegal` and change no accumulator, flag or `regOut`.
- R13: After reset both accumulators, both flags, `regOut`, `illegal` and `valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue one operation this cycle |
| opCode | input | 4 | Operation code (see R2 to R12) |
| accSel | input | 1 | Accumulator index |
| opA | input | 16 | First register operand |
| opB | input | 16 | Second register operand; also supplies shift amounts |
| fracMode | input | 1 | Doubles products when 1 |
| valid | output | 1 | Result of the previous cycle's operation is present |
| illegal | output | 1 | That operation was rejected |
| regOut | output | 16 | Last readout result |
| flagF0 | output | 1 | Primary flag |
| flagF1 | output | 1 | Previous primary flag |
| accOut | output | 40 | Accumulator addressed by the last operation |

## Verification
The hardest states to reach are readout sums that sit exactly on the saturation limits. The load operation can only form sign-extended 32-bit values, so the negative limit cannot be reached by a load alone. The stimulus loads -2^31 and then applies multiply-subtract steps of 0x8000 and of 1. This walks the rounded sum onto -0x80000000 and then one below it. The positive limit is reached directly by loading 0x7FFF7FFF and 0x7FFF8000. All eight readout shift amounts are swept under both fractional settings, and all 32 register shift amounts are swept so that the illegal region is covered completely.

// File: rtl/accPkg.sv
package accPkg;

  typedef enum logic [3:0] {
    OP_LOAD  = 4'd0,
    OP_MUL   = 4'd1,
    OP_MAC   = 4'd2,
    OP_MSB   = 4'd3,
    OP_SRA_R = 4'd4,
    OP_SRL_R = 4'd5,
    OP_SRA_I = 4'd6,
    OP_SRL_I = 4'd7,
    OP_CMP   = 4'd8,
    OP_RND   = 4'd9
  } opKind_e;

  typedef enum logic [2:0] {
    FN_LOAD,
    FN_MUL,
    FN_MAC,
    FN_MSB,
    FN_SRA,
    FN_SRL
  } accFn_e;

  // strobes from control to datapath; all zero when idle
  typedef struct packed {
    logic   wrAcc;
    logic   doCmp;
    logic   doRnd;
    logic   immShift;
    logic   bad;
    accFn_e fn;
  } ctrlStrobe_t;

endpackage

// File: rtl/accCtrl.sv
module accCtrl
  import accPkg::*;
#(
  parameter int SHAMT_W = 5,
  parameter int SHMAX   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [3:0]         opCode,
  input  logic [SHAMT_W-1:0] regAmt,
  output ctrlStrobe_t        strb,
  output logic               validOut
);

  localparam logic [SHAMT_W-1:0] SH_LIM = SHAMT_W'(SHMAX);

  ctrlStrobe_t dec;
  logic        amtOk;

  assign amtOk = (regAmt <= SH_LIM);

  always_comb begin
    dec = '0;
    case (opCode)
      OP_LOAD:  begin dec.wrAcc = 1'b1; dec.fn = FN_LOAD; end
      OP_MUL:   begin dec.wrAcc = 1'b1; dec.fn = FN_MUL;  end
      OP_MAC:   begin dec.wrAcc = 1'b1; dec.fn = FN_MAC;  end
      OP_MSB:   begin dec.wrAcc = 1'b1; dec.fn = FN_MSB;  end
      OP_SRA_R: begin dec.wrAcc = amtOk; dec.bad = !amtOk; dec.fn = FN_SRA; end
      OP_SRL_R: begin dec.wrAcc = amtOk; dec.bad = !amtOk; dec.fn = FN_SRL; end
      OP_SRA_I: begin dec.wrAcc = 1'b1; dec.immShift = 1'b1; dec.fn = FN_SRA; end
      OP_SRL_I: begin dec.wrAcc = 1'b1; dec.immShift = 1'b1; dec.fn = FN_SRL; end
      OP_CMP:   dec.doCmp = 1'b1;
      OP_RND:   dec.doRnd = 1'b1;
      default:  dec.bad = 1'b1;
    endcase
  end

  assign strb = start ? dec : '0;

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= start;
  end

endmodule

// File: rtl/accData.sv
module accData
  import accPkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int REG_W   = 16,
  parameter int NUM_ACC = 2,
  parameter int RSH_W   = 3,
  parameter int SEL_W   = 1,
  parameter int SHAMT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [SEL_W-1:0]  accSel,
  input  logic [REG_W-1:0]  opA,
  input  logic [REG_W-1:0]  opB,
  input  logic              fracMode,
  output logic [ACC_W-1:0]  accOut,
  output logic [REG_W-1:0]  regOut,
  output logic              flagF0,
  output logic              flagF1,
  output logic              illegal
);

  localparam int PROD_W = 2 * REG_W;
  localparam int WIDE_W = ACC_W + 8;
  localparam int IMM_W  = SHAMT_W - 1;

  localparam logic signed [WIDE_W-1:0] HALF =
    {{(WIDE_W-REG_W){1'b0}}, 1'b1, {(REG_W-1){1'b0}}};
  localparam logic signed [WIDE_W-1:0] POS_LIM =
    {{(WIDE_W-PROD_W+1){1'b0}}, {(PROD_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] NEG_LIM =
    {{(WIDE_W-PROD_W+1){1'b1}}, {(PROD_W-1){1'b0}}};

  logic [ACC_W-1:0] accBank [NUM_ACC];
  logic [SEL_W-1:0] lastSel;
  logic [ACC_W-1:0] accCur, accNext, prodAcc, loadVal;
  logic [PROD_W-1:0] rawProd;
  logic [PROD_W:0]   prodX;
  logic [SHAMT_W-1:0] immAmt, shAmt;
  logic signed [ACC_W-1:0] accSigned;
  logic signed [WIDE_W-1:0] wideAcc, shifted, rounded;
  logic [RSH_W-1:0] rAmt, negAmt;
  logic satHi, satLo, cmpEq, anyOp;
  logic [REG_W-1:0] rndOut;

  assign accCur    = accBank[accSel];
  assign accSigned = accCur;

  // product path, optionally doubled
  assign rawProd = opA * opB;
  assign prodX   = fracMode ? {rawProd, 1'b0} : {1'b0, rawProd};
  assign prodAcc = {{(ACC_W-PROD_W-1){1'b0}}, prodX};
  assign loadVal = {{(ACC_W-PROD_W){opA[REG_W-1]}}, opA, opB};

  // shift amount: register low bits, or immediate with 0 meaning full width
  assign immAmt = (opB[IMM_W-1:0] == '0) ? SHAMT_W'(REG_W)
                                         : {1'b0, opB[IMM_W-1:0]};
  assign shAmt  = strb.immShift ? immAmt : opB[SHAMT_W-1:0];

  always_comb begin
    case (strb.fn)
      FN_LOAD: accNext = loadVal;
      FN_MUL:  accNext = prodAcc;
      FN_MAC:  accNext = accCur + prodAcc;
      FN_MSB:  accNext = accCur - prodAcc;
      FN_SRA:  accNext = accSigned >>> shAmt;
      FN_SRL:  accNext = accCur >> shAmt;
      default: accNext = accCur;
    endcase
  end

  // rounded readout of the upper half
  assign wideAcc = {{(WIDE_W-ACC_W){accCur[ACC_W-1]}}, accCur};
  assign rAmt    = opB[RSH_W-1:0];
  assign negAmt  = ~rAmt + 1'b1;
  assign shifted = rAmt[RSH_W-1] ? (wideAcc >>> negAmt) : (wideAcc <<< rAmt);
  assign rounded = shifted + HALF;
  assign satHi   = rounded > POS_LIM;
  assign satLo   = rounded < NEG_LIM;
  assign rndOut  = satHi ? {1'b0, {(REG_W-1){1'b1}}}
                 : satLo ? {1'b1, {(REG_W-1){1'b0}}}
                 : rounded[PROD_W-1:REG_W];

  assign cmpEq = (accBank[0] == accBank[NUM_ACC-1]);
  assign anyOp = strb.wrAcc | strb.doCmp | strb.doRnd | strb.bad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ACC; i++) accBank[i] <= '0;
    end else if (strb.wrAcc) begin
      for (int i = 0; i < NUM_ACC; i++)
        if (accSel == SEL_W'(i)) accBank[i] <= accNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regOut  <= '0;
      flagF0  <= 1'b0;
      flagF1  <= 1'b0;
      illegal <= 1'b0;
      lastSel <= '0;
    end else begin
      illegal <= strb.bad;
      if (anyOp) lastSel <= accSel;
      if (strb.doCmp) begin
        flagF1 <= flagF0;
        flagF0 <= cmpEq;
      end else if (strb.doRnd) begin
        flagF1 <= flagF0;
        flagF0 <= satHi | satLo;
        regOut <= rndOut;
      end
    end
  end

  assign accOut = accBank[lastSel];

endmodule

// File: rtl/dspAccUnit.sv
module dspAccUnit
  import accPkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int REG_W   = 16,
  parameter int NUM_ACC = 2,
  parameter int RSH_W   = 3,
  parameter int SEL_W   = $clog2(NUM_ACC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [3:0]       opCode,
  input  logic [SEL_W-1:0] accSel,
  input  logic [REG_W-1:0] opA,
  input  logic [REG_W-1:0] opB,
  input  logic             fracMode,
  output logic             valid,
  output logic             illegal,
  output logic [REG_W-1:0] regOut,
  output logic             flagF0,
  output logic             flagF1,
  output logic [ACC_W-1:0] accOut
);

  localparam int SHAMT_W = $clog2(REG_W) + 1;

  ctrlStrobe_t strb;

  accCtrl #(.SHAMT_W(SHAMT_W), .SHMAX(REG_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode),
    .regAmt(opB[SHAMT_W-1:0]), .strb(strb), .validOut(valid)
  );

  accData #(
    .ACC_W(ACC_W), .REG_W(REG_W), .NUM_ACC(NUM_ACC), .RSH_W(RSH_W),
    .SEL_W(SEL_W), .SHAMT_W(SHAMT_W)
  ) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .accSel(accSel), .opA(opA),
    .opB(opB), .fracMode(fracMode), .accOut(accOut), .regOut(regOut),
    .flagF0(flagF0), .flagF1(flagF1), .illegal(illegal)
  );

endmodule

// File: rtl/dspAccChk.sv
module dspAccChk #(
  parameter int ACC_W   = 40,
  parameter int REG_W   = 16,
  parameter int NUM_ACC = 2,
  parameter int RSH_W   = 3,
  parameter int SEL_W   = $clog2(NUM_ACC)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [3:0]       opCode,
  input logic [SEL_W-1:0] accSel,
  input logic [REG_W-1:0] opA,
  input logic [REG_W-1:0] opB,
  input logic             fracMode,
  input logic             valid,
  input logic             illegal,
  input logic [REG_W-1:0] regOut,
  input logic             flagF0,
  input logic             flagF1,
  input logic [ACC_W-1:0] accOut
);

  localparam int SHAMT_W = $clog2(REG_W) + 1;
  localparam logic [REG_W-1:0] SAT_P = {1'b0, {(REG_W-1){1'b1}}};
  localparam logic [REG_W-1:0] SAT_N = {1'b1, {(REG_W-1){1'b0}}};

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    start |=> valid);  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !valid);  // R1
  AST_LEGAL_MUL: assert property (@(posedge clk) disable iff (!rstN)
    (start && opCode <= 4'd3) |=> !illegal);  // R2
  AST_SHIFT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (start && (opCode == 4'd4 || opCode == 4'd5) && opB[SHAMT_W-1:0] > SHAMT_W'(REG_W))
    |=> (illegal && $stable(flagF0) && $stable(flagF1)));  // R8
  AST_FLAG_HISTORY: assert property (@(posedge clk) disable iff (!rstN)
    (start && (opCode == 4'd8 || opCode == 4'd9)) |=> (flagF1 == $past(flagF0)));  // R9
  AST_SAT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (start && opCode == 4'd9) |=> (!flagF0 || regOut == SAT_P || regOut == SAT_N));  // R11
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    (start && opCode > 4'd9) |=> (illegal && $stable(regOut) && $stable(flagF0)));  // R12

endmodule

bind dspAccUnit dspAccChk #(
  .ACC_W(ACC_W), .REG_W(REG_W), .NUM_ACC(NUM_ACC), .RSH_W(RSH_W), .SEL_W(SEL_W)
) i_chk (.*);

// File: tb/test_dspAccUnit.sv
`timescale 1ns/1ps
module test_dspAccUnit;

  localparam longint unsigned MASK40 = 64'h00FF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opCode = '0;
  logic        accSel = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        fracMode = 1'b0;
  logic        valid, illegal, flagF0, flagF1;
  logic [15:0] regOut;
  logic [39:0] accOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint unsigned mAcc [2];
  logic mF0 = 1'b0, mF1 = 1'b0, mIll = 1'b0;
  logic [15:0] mReg = '0;

  always #4 clk = ~clk;

  dspAccUnit i_dspAccUnit (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .accSel(accSel),
    .opA(opA), .opB(opB), .fracMode(fracMode), .valid(valid), .illegal(illegal),
    .regOut(regOut), .flagF0(flagF0), .flagF1(flagF1), .accOut(accOut)
  );

  task automatic chk(input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic longint signed sx40(input longint unsigned v);
    return $signed(v << 24) >>> 24;
  endfunction

  task automatic model(input logic [3:0] op, input int sel, input logic [15:0] a,
                       input logic [15:0] b, input logic fx, output string tag);
    longint unsigned p;
    longint signed s;
    int amt, ri;
    logic signed [31:0] t;
    mIll = 1'b0;
    p = longint'(a) * longint'(b);
    if (fx) p = p << 1;
    case (op)
      4'd0: begin t = $signed({a, b}); s = t; mAcc[sel] = s & MASK40; tag = "R5"; end
      4'd1: begin mAcc[sel] = p; tag = "R2"; end
      4'd2: begin mAcc[sel] = (mAcc[sel] + p) & MASK40; tag = "R3"; end
      4'd3: begin mAcc[sel] = (mAcc[sel] - p) & MASK40; tag = "R4"; end
      4'd4, 4'd5, 4'd6, 4'd7: begin
        if (op < 4'd6) amt = int'(b[4:0]);
        else amt = (b[3:0] == 4'd0) ? 16 : int'(b[3:0]);
        tag = (op == 4'd4 || op == 4'd6) ? "R6" : "R7";
        if (op < 4'd6 && amt > 16) begin
          mIll = 1'b1; tag = "R8";
        end else if (op == 4'd4 || op == 4'd6)
          mAcc[sel] = longint'(sx40(mAcc[sel]) >>> amt) & MASK40;
        else
          mAcc[sel] = mAcc[sel] >> amt;
      end
      4'd8: begin mF1 = mF0; mF0 = (mAcc[0] == mAcc[1]); tag = "R9"; end
      4'd9: begin
        s = sx40(mAcc[sel]);
        ri = $signed(b[2:0]);
        if (ri >= 0) s = s <<< ri; else s = s >>> (-ri);
        s = s + 64'sd32768;
        mF1 = mF0;
        if (s > 64'sh7FFF_FFFF) begin mReg = 16'h7FFF; mF0 = 1'b1; tag = "R11"; end
        else if (s < -64'sh8000_0000) begin mReg = 16'h8000; mF0 = 1'b1; tag = "R11"; end
        else begin mReg = s[31:16]; mF0 = 1'b0; tag = "R10"; end
      end
      default: begin mIll = 1'b1; tag = "R12"; end
    endcase
  endtask

  task automatic doOp(input logic [3:0] op, input int sel, input logic [15:0] a,
                      input logic [15:0] b, input logic fx);
    string tag;
    @(negedge clk);
    start = 1'b1; opCode = op; accSel = sel[0]; opA = a; opB = b; fracMode = fx;
    model(op, sel, a, b, fx, tag);
    @(negedge clk);
    start = 1'b0;
    chk("R1", "valid", longint'(valid), 1);
    chk(tag, "illegal", longint'(illegal), longint'(mIll));
    chk(tag, "accOut", longint'(accOut), mAcc[sel]);
    chk(tag, "regOut", longint'(regOut), longint'(mReg));
    chk(tag, "flagF0", longint'(flagF0), longint'(mF0));
    chk(tag, "flagF1", longint'(flagF1), longint'(mF1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mAcc[0] = 0; mAcc[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13", "valid", longint'(valid), 0);
    chk("R13", "accOut", longint'(accOut), 0);
    chk("R13", "regOut", longint'(regOut), 0);
    chk("R13", "flags", longint'({flagF0, flagF1, illegal}), 0);

    // positive limit: exactly at, then one above (R11, R10)
    doOp(4'd0, 0, 16'h7FFF, 16'h7FFF, 1'b0);
    doOp(4'd9, 0, 16'h0000, 16'h0000, 1'b0);
    doOp(4'd0, 0, 16'h7FFF, 16'h8000, 1'b0);
    doOp(4'd9, 0, 16'h0000, 16'h0000, 1'b0);
    // negative limit via subtract steps (R11, R4)
    doOp(4'd0, 1, 16'h8000, 16'h0000, 1'b0);
    doOp(4'd3, 1, 16'h8000, 16'h0001, 1'b0);
    doOp(4'd9, 1, 16'h0000, 16'h0000, 1'b0);
    doOp(4'd3, 1, 16'h0001, 16'h0001, 1'b0);
    doOp(4'd9, 1, 16'h0000, 16'h0000, 1'b0);
    // equal accumulators for the compare (R9)
    doOp(4'd0, 0, 16'h1234, 16'h5678, 1'b0);
    doOp(4'd0, 1, 16'h1234, 16'h5678, 1'b0);
    doOp(4'd8, 0, 16'h0000, 16'h0000, 1'b0);
    doOp(4'd8, 1, 16'h0000, 16'h0000, 1'b0);
    // largest products with and without doubling (R2)
    doOp(4'd1, 0, 16'hFFFF, 16'hFFFF, 1'b1);
    doOp(4'd1, 1, 16'hFFFF, 16'hFFFF, 1'b0);
    // negative value for arithmetic shifts; every register amount (R6 R7 R8)
    for (int amt = 0; amt < 32; amt++) begin
      doOp(4'd0, amt % 2, 16'h8765, 16'h4321, 1'b0);
      doOp(4'd3, amt % 2, 16'hFFFF, 16'h00FF, 1'b0);
      doOp(4'd4, amt % 2, 16'h0000, 16'(amt), 1'b0);
      doOp(4'd5, 1 - amt % 2, 16'h0000, 16'(amt), 1'b0);
    end
    // every immediate amount including 0 meaning 16 (R6 R7)
    for (int amt = 0; amt < 16; amt++) begin
      doOp(4'd3, 0, 16'hFFFF, 16'hFFFF, 1'b1);
      doOp(4'd6, 0, 16'h0000, 16'(amt), 1'b0);
      doOp(4'd3, 1, 16'hFFFF, 16'hFFFF, 1'b1);
      doOp(4'd7, 1, 16'h0000, 16'(amt), 1'b0);
    end
    // every readout shift under both modes (R10 R11)
    for (int r = 0; r < 8; r++) begin
      for (int fx = 0; fx < 2; fx++) begin
        doOp(4'd0, 0, 16'($urandom), 16'($urandom), 1'b0);
        doOp(4'd2, 0, 16'($urandom), 16'($urandom), fx[0]);
        doOp(4'd9, 0, 16'h0000, 16'(r), 1'b0);
        doOp(4'd0, 1, 16'h0000, 16'($urandom), 1'b0);
        doOp(4'd9, 1, 16'h0000, 16'(r), 1'b0);
      end
    end
    // undefined codes (R12)
    for (int op = 10; op < 16; op++) doOp(4'(op), op % 2, 16'hFFFF, 16'h0003, 1'b1);
    // idle cycle gives no valid (R1)
    @(negedge clk);
    chk("R1", "idle valid", longint'(valid), 0);
    // random sweep across all codes (R2 R3 R4 R5 R9 R10)
    for (int n = 0; n < 1500; n++)
      doOp(4'($urandom_range(0, 15)), int'($urandom_range(0, 1)),
           16'($urandom), 16'($urandom), 1'($urandom));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule